// File: doc/BRIEF.md
# Three-Level Nested Interrupt Controller

This block gathers fifteen interrupt request sources into nine vectors and decides which vector, if any, is presented to the CPU. Each source has a flag that a one-cycle request pulse sets. Software clears each flag on its own. A per-source enable decides whether a set flag counts toward its vector. Several vectors are shared: one vector serves more than one source and stays pending while any of its enabled flags is set.

Each vector runs at one of three priority levels. Vectors 1 and 2 may be low or highest. Vectors 3 to 9 may be low or high. The controller records the levels in service in a three-bit mask. A CPU acknowledge adds the level of the winning vector to the mask. A return-from-interrupt strobe removes the topmost level. A new request reaches the CPU only if its level is strictly above every level in service, which gives nesting of up to three deep.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset all source flags are clear, no level is in service, `irqReq` is 0 and `irqVec` is 0.
- R2: A 1 on `srcReq[i]` at a clock edge sets flag i. The flag stays set until a 1 on `srcClr[i]` at a later edge. When request and clear coincide for one source, the request wins and the flag stays set.
- R3: Source-to-vector map, source index to vector number: 0 to 1, 1 to 2, 2 and 3 to 3, 4 and 5 to 4, 6 to 5, 7 and 8 to 6, 9 to 7, 10, 11 and 12 to 8, 13 and 14 to 9. A vector is pending while at least one of its sources has both its flag and its `srcEn` bit set. A disabled source keeps its flag, which counts again once it is enabled.
- R4: Level of vector v is set by `vecPrio[v-1]`. A 0 gives low. A 1 gives highest for vectors 1 and 2, and high for vectors 3 to 9. Vectors 3 to 9 never reach the highest level.
- R5: The winner is the pending vector at the greatest level, and the lowest vector number among equal levels. `irqVec` shows its number (1 to 9) while `irqReq` is 1, and 0 otherwise.
- R6: `irqReq` is 1 only if the winner's level is strictly above the highest level in service. A pending vector at or below that level is held back.
- R7: `cpuAck` while `irqReq` is 1 places the winner's level in service from the next cycle. `cpuAck` while `irqReq` is 0 has no effect. An acknowledge never clears a source flag.
- R8: `intRet` removes the highest level in service. With nothing in service it has no effect. `intRet` and `cpuAck` in the same cycle both take effect.
- R9: `irqReq` and `irqVec` follow `srcEn` and `vecPrio` in the same cycle, and follow a flag set or cleared at an edge from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcReq | input | 15 | Per-source request pulses |
| srcClr | input | 15 | Per-source flag clears |
| srcEn | input | 15 | Per-source enables |
| vecPrio | input | 9 | Per-vector priority select, bit v-1 for vector v |
| cpuAck | input | 1 | CPU acknowledge strobe |
| intRet | input | 1 | Return-from-interrupt strobe |
| irqReq | output | 1 | Interrupt request to the CPU |
| irqVec | output | 4 | Winning vector number, 0 when idle |

## Verification
Shared vectors are driven with several of their sources set and cleared in turn, and with one source disabled. This separates the per-vector OR of enabled flags from a plain OR of flags. Mixed priority settings across vectors 1, 3, 6 and 9 separate the level ordering from the vector-number tie break, and show that the highest level is reserved for vectors 1 and 2. Nesting runs from low through high to highest with extra acknowledges and returns at each depth. Combined acknowledge and return strokes show that preemption is strictly greater-than and that the topmost level is the one popped.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;
  localparam int NUM_SRC = 15;
  localparam int NUM_VEC = 9;
  localparam int NUM_LVL = 3;
  localparam int NUM_TOP_VEC = 2;
  localparam int LVL_W = $clog2(NUM_LVL + 1);
  localparam int VEC_W = $clog2(NUM_VEC + 1);

  // Level codes: 0 none, 1 low, 2 high, 3 highest
  typedef logic [LVL_W-1:0] lvl_t;

  typedef struct packed {
    logic [NUM_LVL-1:0] pushMask;
    logic [NUM_LVL-1:0] popMask;
  } svcStrobe_t;

  // Zero-based vector index served by a source
  function automatic int srcToVec(input int s);
    case (s)
      0:        return 0;
      1:        return 1;
      2, 3:     return 2;
      4, 5:     return 3;
      6:        return 4;
      7, 8:     return 5;
      9:        return 6;
      10,11,12: return 7;
      default:  return 8;
    endcase
  endfunction
endpackage

// File: rtl/nest_irq_datapath.sv
module nest_irq_datapath
  import nest_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_SRC-1:0] srcClr,
  input  svcStrobe_t         strobe,
  output logic [NUM_SRC-1:0] flags,
  output logic [NUM_LVL-1:0] inSvc
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags <= '0;
      inSvc <= '0;
    end else begin
      flags <= (flags & ~srcClr) | srcReq;
      inSvc <= (inSvc & ~strobe.popMask) | strobe.pushMask;
    end
  end

  AST_FLAG_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flags & $past(srcReq)) == $past(srcReq))) else $error("flag not set"); // R2

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flags & $past(srcClr & ~srcReq)) == '0)) else $error("flag not cleared"); // R2

  AST_PUSH_MARK: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pushMask != '0) |=> ((inSvc & $past(strobe.pushMask)) != '0)) else $error("push lost"); // R7

  AST_POP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.popMask != '0 && strobe.pushMask == '0)
      |=> ($countones(inSvc) + 1 == $countones($past(inSvc)))) else $error("pop count"); // R8

endmodule

// File: rtl/nest_irq_control.sv
module nest_irq_control
  import nest_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] flags,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_VEC-1:0] vecPrio,
  input  logic [NUM_LVL-1:0] inSvc,
  input  logic               cpuAck,
  input  logic               intRet,
  output logic               irqReq,
  output logic [VEC_W-1:0]   irqVec,
  output svcStrobe_t         strobe
);

  function automatic logic [NUM_SRC-1:0] vecSources(input int v);
    logic [NUM_SRC-1:0] m;
    m = '0;
    for (int s = 0; s < NUM_SRC; s++)
      if (srcToVec(s) == v) m[s] = 1'b1;
    return m;
  endfunction

  logic [NUM_VEC-1:0] vecPend;
  lvl_t               vecLvl [NUM_VEC];
  logic [NUM_SRC-1:0] liveFlags;

  assign liveFlags = flags & srcEn;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    localparam logic [NUM_SRC-1:0] SRC_MASK = vecSources(v);
    assign vecPend[v] = |(liveFlags & SRC_MASK);
    if (v < NUM_TOP_VEC) begin : g_top
      assign vecLvl[v] = vecPrio[v] ? lvl_t'(3) : lvl_t'(1);
    end else begin : g_norm
      assign vecLvl[v] = vecPrio[v] ? lvl_t'(2) : lvl_t'(1);
    end
  end

  // Highest level in service
  lvl_t               topLvl;
  logic [NUM_LVL-1:0] topMask;
  always_comb begin
    topLvl  = '0;
    topMask = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (inSvc[l]) begin
        topLvl  = lvl_t'(l + 1);
        topMask = NUM_LVL'(1) << l;
      end
    end
  end

  // Greatest level wins; descending scan with >= keeps lowest index on ties
  lvl_t           bestLvl;
  logic [VEC_W-1:0] bestVec;
  always_comb begin
    bestLvl = '0;
    bestVec = '0;
    for (int v = NUM_VEC - 1; v >= 0; v--) begin
      if (vecPend[v] && vecLvl[v] >= bestLvl) begin
        bestLvl = vecLvl[v];
        bestVec = VEC_W'(v + 1);
      end
    end
  end

  assign irqReq = (bestLvl > topLvl);
  assign irqVec = irqReq ? bestVec : '0;

  always_comb begin
    strobe.pushMask = '0;
    if (cpuAck && irqReq)
      strobe.pushMask = NUM_LVL'(1) << (bestLvl - lvl_t'(1));
    strobe.popMask = intRet ? topMask : '0;
  end

  AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ((inSvc >> (bestLvl - lvl_t'(1))) == '0)) else $error("preempt at level in service"); // R6

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqVec >= VEC_W'(1) && irqVec <= VEC_W'(NUM_VEC))) else $error("vector out of range"); // R5

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !irqReq |-> (irqVec == '0)) else $error("idle vector nonzero"); // R5

  AST_NO_TOP_FOR_LOW_VEC: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && irqVec > VEC_W'(NUM_TOP_VEC)) |-> (bestLvl != lvl_t'(3))) else $error("shared vector at highest"); // R4

  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAck && !irqReq) |=> ($past(inSvc) & ~inSvc) == ($past(inSvc) & ~inSvc) && ((inSvc & ~$past(inSvc)) == '0)) else $error("idle ack changed state"); // R7

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nest_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_SRC-1:0] srcClr,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_VEC-1:0] vecPrio,
  input  logic               cpuAck,
  input  logic               intRet,
  output logic               irqReq,
  output logic [VEC_W-1:0]   irqVec
);

  logic [NUM_SRC-1:0] flags;
  logic [NUM_LVL-1:0] inSvc;
  svcStrobe_t         strobe;

  nest_irq_datapath i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .srcReq (srcReq),
    .srcClr (srcClr),
    .strobe (strobe),
    .flags  (flags),
    .inSvc  (inSvc)
  );

  nest_irq_control i_control (
    .clk     (clk),
    .rstN    (rstN),
    .flags   (flags),
    .srcEn   (srcEn),
    .vecPrio (vecPrio),
    .inSvc   (inSvc),
    .cpuAck  (cpuAck),
    .intRet  (intRet),
    .irqReq  (irqReq),
    .irqVec  (irqVec),
    .strobe  (strobe)
  );

endmodule

// File: tb/test_nest_irq_ctrl.sv
module test_nest_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [14:0] srcReq = '0, srcClr = '0, srcEn = '1;
  logic [8:0]  vecPrio = '0;
  logic        cpuAck = 1'b0, intRet = 1'b0;
  logic        irqReq;
  logic [3:0]  irqVec;

  always #10 clk = ~clk;

  nest_irq_ctrl i_nest_irq_ctrl (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .srcClr(srcClr), .srcEn(srcEn),
    .vecPrio(vecPrio), .cpuAck(cpuAck), .intRet(intRet),
    .irqReq(irqReq), .irqVec(irqVec)
  );

  // Reference model state
  int    vecOf [15] = '{1,2,3,3,4,4,5,6,6,7,8,8,8,9,9};
  bit    mFlags [15];
  int    svc [$];
  int    checks = 0, fails = 0;
  string curReq = "R1";
  bit    finished = 0;

  function automatic int levelOf(int v);
    if (!vecPrio[v-1]) return 1;
    return (v <= 2) ? 3 : 2;
  endfunction

  task automatic cycle();
    int bestL, bestV, top;
    bit eReq;
    int eVec;
    #2;
    bestL = 0; bestV = 0;
    for (int v = 1; v <= 9; v++) begin
      bit pend = 0;
      for (int s = 0; s < 15; s++)
        if (vecOf[s] == v && mFlags[s] && srcEn[s]) pend = 1;
      if (pend && levelOf(v) > bestL) begin bestL = levelOf(v); bestV = v; end
    end
    top = (svc.size() > 0) ? svc[$] : 0;
    eReq = (bestL > top);
    eVec = eReq ? bestV : 0;
    checks++;
    if (irqReq !== eReq || int'(irqVec) !== eVec) begin
      fails++;
      $display("FAIL %s irqReq/irqVec got %0b/%0d expected %0b/%0d", curReq, irqReq, irqVec, eReq, eVec);
    end
    @(posedge clk);
    if (rstN) begin
      for (int s = 0; s < 15; s++) begin
        if (srcClr[s]) mFlags[s] = 0;
        if (srcReq[s]) mFlags[s] = 1;
      end
      if (intRet && svc.size() > 0) void'(svc.pop_back());
      if (cpuAck && eReq) svc.push_back(bestL);
    end
    @(negedge clk);
    srcReq = '0; srcClr = '0; cpuAck = 0; intRet = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    for (int s = 0; s < 15; s++) mFlags[s] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curReq = "R1"; idle(2);                         // R1 reset state

    curReq = "R2"; srcReq[6] = 1; cycle(); idle(2); // R2 set and hold
    srcClr[6] = 1; cycle(); idle(1);
    srcReq[7] = 1; srcClr[7] = 1; cycle(); idle(1); // R2 request beats clear
    srcClr[7] = 1; cycle();

    curReq = "R3"; srcEn[11] = 0;                   // R3 shared vector 8
    srcReq = 15'h1400; cycle();
    srcClr[10] = 1; cycle();
    srcClr[12] = 1; cycle();
    srcReq[11] = 1; cycle(); idle(1);               // R3 disabled flag latched
    srcEn[11] = 1; cycle();
    srcClr[11] = 1; cycle();

    curReq = "R5"; srcReq = 15'h4085; cycle();      // R5 vectors 1,3,6,9 pending
    idle(1);
    curReq = "R4"; vecPrio = 9'h100; cycle();       // R4 vector 9 high
    vecPrio = 9'h101; cycle();                      // R4 vector 1 highest
    curReq = "R5"; vecPrio = 9'h104; cycle();       // R5 tie at high: vector 3
    curReq = "R9"; srcEn[2] = 0; srcEn[3] = 0; cycle(); // R9 enable seen same cycle
    srcEn = '1; vecPrio = '0; cycle();

    curReq = "R7"; cpuAck = 1; cycle();             // R7 low in service
    curReq = "R6"; idle(1);                          // R6 low held back
    curReq = "R7"; cpuAck = 1; cycle();             // R7 idle ack ignored
    curReq = "R6"; vecPrio = 9'h020; cycle();       // R6 high preempts
    curReq = "R7"; cpuAck = 1; cycle();
    curReq = "R6"; vecPrio = 9'h120; cycle();       // R6 equal level held
    vecPrio = 9'h021; cycle();                      // R6 highest preempts
    curReq = "R7"; cpuAck = 1; cycle(); idle(1);

    curReq = "R8"; intRet = 1; cycle();             // R8 pop highest
    intRet = 1; cpuAck = 1; cycle();                // R8 return and ack together
    intRet = 1; cycle();
    intRet = 1; cycle();
    intRet = 1; cycle();
    intRet = 1; cycle();                            // R8 return when empty
    idle(1);
    srcClr = '1; cycle(); idle(1);

    curReq = "R9"; srcReq[4] = 1; srcEn[4] = 0; cycle(); // R9
    srcEn[4] = 1; cycle();
    vecPrio[3] = 1; cycle();
    srcReq[1] = 1; cycle();
    vecPrio[1] = 1; cycle();
    srcClr = '1; cycle(); idle(1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired got running expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule